// File: doc/BRIEF.md
# Debug Run-Control and Single-Step Unit

This unit sits beside a processor core and decides how the core responds to debug events. It watches an instruction-retired strobe, a decoded HALT strobe with the current privilege level, trace-exception requests, pending interrupt lines and a GO command from the debug link. From these it drives a level halt request, a gated copy of the interrupt lines, one-cycle fault flags for a refused HALT, and a pair of one-cycle strobes that route a trace exception.

When stepping is enabled, the core stops after every retired instruction. Each GO releases it for exactly one more instruction. A separate configuration bit can silence interrupts while stepping. A HALT instruction needs the debug-enable bit. It also needs either supervisor mode or a bit that permits user-level halts.

Top module: `dbg_run_ctl`

## Requirements
- R1: After reset, `halt_req`, `illegal_op`, `priv_viol`, `trace_emu` and `trace_sup` are 0.
- R2: With `cfg_step_en` = 1, a `retire` pulse while `halt_req` is 0 sets `halt_req` on the next cycle. `halt_req` then stays 1 until a GO is accepted.
- R3: A `go_cmd` while `halt_req` is 1 clears `halt_req` on the next cycle. With stepping still enabled, the next `retire` sets it again, so one instruction runs per GO. A `retire` seen while halted changes nothing.
- R4: A `go_cmd` while `halt_req` is 0 has no effect: `halt_req` stays 0.
- R5: `irq_fwd` is all zeros while both `cfg_step_en` and `cfg_irq_quiet` are 1. Otherwise it equals `irq_pend` in the same cycle.
- R6: A `halt_insn` pulse with `cfg_dbg_en` = 0 pulses `illegal_op` for one cycle on the next cycle. It does not halt the core.
- R7: A `halt_insn` pulse with `cfg_dbg_en` = 1 halts the core on the next cycle in either of two cases: `user_mode` = 0 (supervisor), or `user_mode` = 1 with `cfg_user_halt_ok` = 1.
- R8: A `halt_insn` pulse with `cfg_dbg_en` = 1, `user_mode` = 1 and `cfg_user_halt_ok` = 0 pulses `priv_viol` on the next cycle. It does not halt the core.
- R9: A `trace_req` pulse produces exactly one one-cycle strobe on the next cycle. The strobe is `trace_emu` when `cfg_trace_emu` = 1 and `trace_sup` when it is 0.
- R10: If `cfg_step_en` is cleared while halted and GO is then given, the core resumes. Later retires do not halt it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_step_en | input | 1 | Single-step enable |
| cfg_irq_quiet | input | 1 | Mask interrupts while stepping |
| cfg_user_halt_ok | input | 1 | Allow HALT from user mode |
| cfg_trace_emu | input | 1 | Route trace exceptions to emulator mode |
| cfg_dbg_en | input | 1 | Debug enable; HALT is legal only when set |
| retire | input | 1 | Instruction retired strobe |
| halt_insn | input | 1 | Decoded HALT instruction strobe |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| trace_req | input | 1 | Trace exception request |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| go_cmd | input | 1 | GO command from the debug link |
| halt_req | output | 1 | Level halt request to the core |
| irq_fwd | output | IRQ_W | Interrupt lines after stepping mask |
| illegal_op | output | 1 | HALT refused: debug disabled |
| priv_viol | output | 1 | HALT refused: user mode not permitted |
| trace_emu | output | 1 | Trace exception goes to emulator mode |
| trace_sup | output | 1 | Trace exception goes to supervisor handling |

## Verification
The bench repeats GO several times while stepping, and tries a second retire while halted. A design that let more than one instruction through per GO would keep `halt_req` low for too long. A design that latched on a retire seen while halted would show the error as well. A stray GO while running and a GO after clearing the stepping bit catch designs that arm a halt from GO or keep stepping after the bit is gone. The two refusal paths for HALT and the mask in both configuration combinations are each driven. A design that mixes up the privilege and enable gating would raise the wrong flag or halt the core.

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl #(
  parameter int IRQ_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_step_en,
  input  logic             cfg_irq_quiet,
  input  logic             cfg_user_halt_ok,
  input  logic             cfg_trace_emu,
  input  logic             cfg_dbg_en,
  input  logic             retire,
  input  logic             halt_insn,
  input  logic             user_mode,
  input  logic             trace_req,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic             go_cmd,
  output logic             halt_req,
  output logic [IRQ_W-1:0] irq_fwd,
  output logic             illegal_op,
  output logic             priv_viol,
  output logic             trace_emu,
  output logic             trace_sup
);

  logic halted_q, illegal_q, priv_q, emu_q, sup_q;

  wire step_stop = cfg_step_en & retire & ~halted_q;
  wire halt_try  = halt_insn & ~halted_q;
  wire priv_ok   = ~user_mode | cfg_user_halt_ok;
  wire halt_take = halt_try & cfg_dbg_en & priv_ok;
  wire go_take   = go_cmd & halted_q;
  wire irq_hold  = cfg_step_en & cfg_irq_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
      priv_q    <= 1'b0;
      emu_q     <= 1'b0;
      sup_q     <= 1'b0;
    end else begin
      halted_q  <= go_take ? 1'b0 : (halted_q | step_stop | halt_take);
      illegal_q <= halt_try & ~cfg_dbg_en;
      priv_q    <= halt_try & cfg_dbg_en & ~priv_ok;
      emu_q     <= trace_req & cfg_trace_emu;
      sup_q     <= trace_req & ~cfg_trace_emu;
    end
  end

  assign halt_req   = halted_q;
  assign irq_fwd    = irq_hold ? '0 : irq_pend;
  assign illegal_op = illegal_q;
  assign priv_viol  = priv_q;
  assign trace_emu  = emu_q;
  assign trace_sup  = sup_q;

endmodule

module dbg_run_ctl_chk #(
  parameter int IRQ_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_step_en,
  input logic             cfg_irq_quiet,
  input logic             cfg_user_halt_ok,
  input logic             cfg_trace_emu,
  input logic             cfg_dbg_en,
  input logic             retire,
  input logic             halt_insn,
  input logic             user_mode,
  input logic             trace_req,
  input logic             go_cmd,
  input logic             halt_req,
  input logic [IRQ_W-1:0] irq_fwd,
  input logic             illegal_op,
  input logic             priv_viol,
  input logic             trace_emu,
  input logic             trace_sup
);

  p_step_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && cfg_step_en && retire) |=> halt_req);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !go_cmd) |=> halt_req);

  p_go_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && go_cmd) |=> !halt_req);

  p_go_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && go_cmd && !retire && !halt_insn) |=> !halt_req);

  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_step_en && cfg_irq_quiet) |-> (irq_fwd == '0));

  p_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && halt_insn && !cfg_dbg_en && !(retire && cfg_step_en))
      |=> (illegal_op && !priv_viol && !halt_req));

  p_halt_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && halt_insn && cfg_dbg_en && (!user_mode || cfg_user_halt_ok))
      |=> (halt_req && !illegal_op && !priv_viol));

  p_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && halt_insn && cfg_dbg_en && user_mode && !cfg_user_halt_ok
      && !(retire && cfg_step_en)) |=> (priv_viol && !halt_req));

  p_trace_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |=> ($countones({trace_emu, trace_sup}) == 1));

  p_trace_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req && cfg_trace_emu) |=> trace_emu);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_op, priv_viol}));

  p_free_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && !cfg_step_en && !halt_insn) |=> !halt_req);

endmodule

bind dbg_run_ctl dbg_run_ctl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_step_en(cfg_step_en), .cfg_irq_quiet(cfg_irq_quiet),
  .cfg_user_halt_ok(cfg_user_halt_ok), .cfg_trace_emu(cfg_trace_emu),
  .cfg_dbg_en(cfg_dbg_en), .retire(retire), .halt_insn(halt_insn),
  .user_mode(user_mode), .trace_req(trace_req), .go_cmd(go_cmd),
  .halt_req(halt_req), .irq_fwd(irq_fwd), .illegal_op(illegal_op),
  .priv_viol(priv_viol), .trace_emu(trace_emu), .trace_sup(trace_sup)
);

// File: tb/dbg_run_ctl_test.sv
module dbg_run_ctl_test;
  localparam int IRQ_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_step_en = 0, cfg_irq_quiet = 0, cfg_user_halt_ok = 0;
  logic cfg_trace_emu = 0, cfg_dbg_en = 0;
  logic retire = 0, halt_insn = 0, user_mode = 0, trace_req = 0, go_cmd = 0;
  logic [IRQ_W-1:0] irq_pend = '0;
  logic halt_req, illegal_op, priv_viol, trace_emu, trace_sup;
  logic [IRQ_W-1:0] irq_fwd;

  always #4 clk = ~clk;

  dbg_run_ctl #(.IRQ_W(IRQ_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_step_en(cfg_step_en), .cfg_irq_quiet(cfg_irq_quiet),
    .cfg_user_halt_ok(cfg_user_halt_ok), .cfg_trace_emu(cfg_trace_emu),
    .cfg_dbg_en(cfg_dbg_en), .retire(retire), .halt_insn(halt_insn),
    .user_mode(user_mode), .trace_req(trace_req), .irq_pend(irq_pend),
    .go_cmd(go_cmd), .halt_req(halt_req), .irq_fwd(irq_fwd),
    .illegal_op(illegal_op), .priv_viol(priv_viol),
    .trace_emu(trace_emu), .trace_sup(trace_sup)
  );

  typedef struct packed { int cyc; int sig; int val; int req; } item_t;
  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam int S_HALT = 0, S_ILL = 1, S_PRIV = 2, S_EMU = 3, S_SUP = 4, S_IRQ = 5;

  function automatic int sample(int s);
    case (s)
      S_HALT: return int'(halt_req);
      S_ILL:  return int'(illegal_op);
      S_PRIV: return int'(priv_viol);
      S_EMU:  return int'(trace_emu);
      S_SUP:  return int'(trace_sup);
      default: return int'(irq_fwd);
    endcase
  endfunction

  task automatic expect_at(int dc, int s, int v, int r);
    item_t it;
    it.cyc = cyc + dc; it.sig = s; it.val = v; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        int act;
        act = sample(sbq[i].sig);
        checks++;
        if (act != sbq[i].val) begin
          fails++;
          $display("FAIL R%0d sig %0d cycle %0d: actual %0d expected %0d",
                   sbq[i].req, sbq[i].sig, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) expect_at(1, s, 0, 1); // R1 reset state
    tick();

    go_cmd = 1; expect_at(1, S_HALT, 0, 4); tick();   // R4 stray GO
    go_cmd = 0; retire = 1; expect_at(1, S_HALT, 0, 4); tick();
    retire = 0;

    cfg_dbg_en = 0; halt_insn = 1;                     // R6 debug disabled
    expect_at(1, S_ILL, 1, 6); expect_at(1, S_HALT, 0, 6); expect_at(1, S_PRIV, 0, 6);
    tick();
    halt_insn = 0; expect_at(1, S_ILL, 0, 6); tick();

    cfg_dbg_en = 1; user_mode = 1; cfg_user_halt_ok = 0; halt_insn = 1; // R8
    expect_at(1, S_PRIV, 1, 8); expect_at(1, S_HALT, 0, 8); expect_at(1, S_ILL, 0, 8);
    tick();
    halt_insn = 0; expect_at(1, S_PRIV, 0, 8); expect_at(1, S_HALT, 0, 8); tick();

    user_mode = 0; halt_insn = 1;                      // R7 supervisor
    expect_at(1, S_HALT, 1, 7); expect_at(1, S_PRIV, 0, 7); tick();
    halt_insn = 0; go_cmd = 1; expect_at(1, S_HALT, 0, 7); tick();
    go_cmd = 0;

    user_mode = 1; cfg_user_halt_ok = 1; halt_insn = 1; // R7 user permitted
    expect_at(1, S_HALT, 1, 7); expect_at(1, S_PRIV, 0, 7); tick();
    halt_insn = 0; go_cmd = 1; expect_at(1, S_HALT, 0, 7); tick();
    go_cmd = 0; user_mode = 0;

    cfg_trace_emu = 1; trace_req = 1;                  // R9 emulator route
    expect_at(1, S_EMU, 1, 9); expect_at(1, S_SUP, 0, 9); tick();
    trace_req = 0; expect_at(1, S_EMU, 0, 9); tick();
    cfg_trace_emu = 0; trace_req = 1;                  // R9 supervisor route
    expect_at(1, S_SUP, 1, 9); expect_at(1, S_EMU, 0, 9); tick();
    trace_req = 0; expect_at(1, S_SUP, 0, 9); tick();

    cfg_step_en = 1; retire = 1; expect_at(1, S_HALT, 1, 2); tick(); // R2
    retire = 0;
    for (int k = 0; k < 3; k++) begin expect_at(1, S_HALT, 1, 2); tick(); end

    for (int k = 0; k < 3; k++) begin                  // R3 one per GO
      go_cmd = 1; expect_at(1, S_HALT, 0, 3); tick();
      go_cmd = 0; retire = 1; expect_at(1, S_HALT, 1, 3); tick();
      expect_at(1, S_HALT, 1, 3); tick();              // retire while halted
      retire = 0;
    end

    cfg_irq_quiet = 1; irq_pend = 7'h55; expect_at(1, S_IRQ, 0, 5); tick(); // R5
    cfg_irq_quiet = 0; expect_at(1, S_IRQ, 'h55, 5); tick();
    cfg_irq_quiet = 1; cfg_step_en = 0; expect_at(1, S_IRQ, 'h55, 5); tick();
    cfg_step_en = 1; irq_pend = 7'h7f; expect_at(1, S_IRQ, 0, 5); tick();
    irq_pend = '0; cfg_irq_quiet = 0;

    cfg_step_en = 0; go_cmd = 1; expect_at(1, S_HALT, 0, 10); tick(); // R10
    go_cmd = 0;
    for (int k = 0; k < 3; k++) begin retire = 1; expect_at(1, S_HALT, 0, 10); tick(); end
    retire = 0;

    repeat (3) tick();
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule